// File: doc/BRIEF.md
# DRAM Page-Policy Command Sequencer

This block sits between a request stream and a DRAM command bus. Each request names a bank, a row, a column and a read/write direction. The block keeps its own record, for every bank, of whether a row is open and which row it is. It compares the request against that record and picks one of three cases. If the bank is idle, the row is opened and then accessed. If the bank holds some other row, that row is closed, the wanted row is opened, and it is then accessed. If the wanted row is already open, it is accessed directly. The block issues the chosen commands one at a time and keeps the per-bank record in step with every open and close it issues.

Both data edges are valid/ready streams. A request is taken only on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while no sequence is in flight and no forced row set-up is being applied, so the block holds exactly one request at a time. Each command stays on the output, with its bank, row and column attached, until a cycle where `cmd_valid` and `cmd_ready` are both high. The command does not change while `cmd_ready` is low. A plain control input lets a row be placed open in a chosen bank without issuing any command, so that hit and conflict cases can be prepared directly. Timing parameters, refresh, the auto-closing access forms and the data path are handled elsewhere.

Top module: `dram_page_sequencer`

## Requirements
- R1: After reset every bank is closed, `req_ready` is 1 and `cmd_valid` is 0, so the first request to any bank yields an open followed by the access.
- R2: A request to a bank with no open row yields exactly two commands: OPEN (code 2), then the access command.
- R3: A request to a bank holding a different row yields exactly three commands: CLOSE (code 0), OPEN (code 2), then the access command.
- R4: A request to a bank that already holds the requested row yields exactly one command: the access command.
- R5: The access command is READ (code 3) when `req_rd` is 1 and WRITE (code 4) when it is 0. Codes 1, 5, 6 and 7 (close-all, read-and-close, write-and-close, refresh) are never issued.
- R6: The case depends only on the bank and row of the request; the column has no effect on it. Every command carries the bank, row and column of its request.
- R7: Issuing OPEN records the row as open in that bank, and issuing CLOSE marks the bank closed. Each bank's record is separate from the others.
- R8: `req_ready` is 0 from the cycle after a request is accepted until the cycle after its access command is handed over, so a second request cannot enter a sequence in flight.
- R9: While `cmd_valid` is 1 and `cmd_ready` is 0, the command code, bank, row and column hold steady and `cmd_valid` stays 1.
- R10: On a cycle with `force_en` high, the bank `force_bank` is recorded as holding `force_row`. `req_ready` is 0 on that cycle.
- R11: The first command is valid in the cycle after acceptance. Each later command is valid in the cycle after the previous one is handed over. `cmd_valid` falls, and `req_ready` rises, in the cycle after the access command is handed over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_rd | input | 1 | 1 for a read, 0 for a write |
| cmd_valid | output | 1 | Command on the output is valid |
| cmd_ready | input | 1 | Command bus takes the command |
| cmd_code | output | 4 | Command code (0 close, 2 open, 3 read, 4 write) |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_row | output | ROW_W | Row of the command |
| cmd_col | output | COL_W | Column of the command |
| force_en | input | 1 | Record a row as open without issuing a command |
| force_bank | input | BANK_W | Bank for the forced set-up |
| force_row | input | ROW_W | Row for the forced set-up |

## Verification
A request accepted at one clock edge shows its first command after that same edge. With `cmd_ready` held high, each following command appears one edge later. `req_ready` comes back one edge after the access command is handed over. The bench drives inputs on the falling edge and samples on the following falling edge, one rising edge after each stimulus. At every sample it checks the command code and its bank, row and column against the sequence the case calls for. It also checks `req_ready` on the falling edge after the last handover. Stall cases hold `cmd_ready` low for several falling edges and recheck that the output is unchanged at each one. Forced set-ups are checked by the command sequence that the next request draws.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [3:0] {
    CMD_CLOSE     = 4'd0,
    CMD_CLOSE_ALL = 4'd1,
    CMD_OPEN      = 4'd2,
    CMD_READ      = 4'd3,
    CMD_WRITE     = 4'd4,
    CMD_READ_CL   = 4'd5,
    CMD_WRITE_CL  = 4'd6,
    CMD_REFRESH   = 4'd7
  } dram_cmd_e;

  typedef enum logic [1:0] {
    PAGE_HIT      = 2'd0,
    PAGE_CLOSED   = 2'd1,
    PAGE_CONFLICT = 2'd2
  } page_case_e;

  // Position in the longest sequence: close, open, access.
  typedef enum logic [1:0] {
    STEP_CLOSE  = 2'd0,
    STEP_OPEN   = 2'd1,
    STEP_ACCESS = 2'd2
  } seq_step_e;

endpackage

// File: rtl/pgseq_row_table.sv
module pgseq_row_table #(
  parameter int BANKS = 8,
  parameter int ROW_W = 14,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] lk_bank,
  output logic              lk_open,
  output logic [ROW_W-1:0]  lk_row,
  input  logic              open_en,
  input  logic [BANK_W-1:0] open_bank,
  input  logic [ROW_W-1:0]  open_row,
  input  logic              close_en,
  input  logic [BANK_W-1:0] close_bank,
  input  logic              force_en,
  input  logic [BANK_W-1:0] force_bank,
  input  logic [ROW_W-1:0]  force_row
);

  logic [BANKS-1:0] open_vec;
  logic [ROW_W-1:0] row_arr [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic             hit_force, hit_open, hit_close;

    assign hit_force = force_en && (force_bank == BANK_W'(b));
    assign hit_open  = open_en  && (open_bank  == BANK_W'(b));
    assign hit_close = close_en && (close_bank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else if (hit_force) begin
        open_q <= 1'b1;
        row_q  <= force_row;
      end else if (hit_open) begin
        open_q <= 1'b1;
        row_q  <= open_row;
      end else if (hit_close) begin
        open_q <= 1'b0;
      end
    end

    assign open_vec[b] = open_q;
    assign row_arr[b]  = row_q;
  end

  always_comb begin
    lk_open = 1'b0;
    lk_row  = '0;
    if (int'(lk_bank) < BANKS) begin
      lk_open = open_vec[lk_bank];
      lk_row  = row_arr[lk_bank];
    end
  end

endmodule

// File: rtl/pgseq_classifier.sv
module pgseq_classifier
  import dram_seq_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  logic             bank_open,
  input  logic [ROW_W-1:0] bank_row,
  input  logic [ROW_W-1:0] want_row,
  input  logic             want_rd,
  output page_case_e       kind,
  output seq_step_e        first_step,
  output dram_cmd_e        access_cmd
);

  always_comb begin
    if (!bank_open)                kind = PAGE_CLOSED;
    else if (bank_row != want_row) kind = PAGE_CONFLICT;
    else                           kind = PAGE_HIT;
  end

  always_comb begin
    unique case (kind)
      PAGE_CONFLICT: first_step = STEP_CLOSE;
      PAGE_CLOSED:   first_step = STEP_OPEN;
      default:       first_step = STEP_ACCESS;
    endcase
  end

  assign access_cmd = want_rd ? CMD_READ : CMD_WRITE;

endmodule

// File: rtl/pgseq_issue.sv
module pgseq_issue
  import dram_seq_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  seq_step_e         take_step,
  input  dram_cmd_e         take_access,
  input  logic [BANK_W-1:0] take_bank,
  input  logic [ROW_W-1:0]  take_row,
  input  logic [COL_W-1:0]  take_col,
  output logic              busy,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output dram_cmd_e         cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic              issued_open,
  output logic              issued_close
);

  logic              busy_q;
  seq_step_e         step_q;
  dram_cmd_e         access_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              handover;

  assign handover = busy_q && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      step_q   <= STEP_ACCESS;
      access_q <= CMD_READ;
      bank_q   <= '0;
      row_q    <= '0;
      col_q    <= '0;
    end else if (!busy_q) begin
      if (take) begin
        busy_q   <= 1'b1;
        step_q   <= take_step;
        access_q <= take_access;
        bank_q   <= take_bank;
        row_q    <= take_row;
        col_q    <= take_col;
      end
    end else if (handover) begin
      unique case (step_q)
        STEP_CLOSE: step_q <= STEP_OPEN;
        STEP_OPEN:  step_q <= STEP_ACCESS;
        default:    busy_q <= 1'b0;
      endcase
    end
  end

  always_comb begin
    unique case (step_q)
      STEP_CLOSE: cmd_code = CMD_CLOSE;
      STEP_OPEN:  cmd_code = CMD_OPEN;
      default:    cmd_code = access_q;
    endcase
  end

  assign busy         = busy_q;
  assign cmd_valid    = busy_q;
  assign cmd_bank     = bank_q;
  assign cmd_row      = row_q;
  assign cmd_col      = col_q;
  assign issued_open  = handover && (step_q == STEP_OPEN);
  assign issued_close = handover && (step_q == STEP_CLOSE);

endmodule

// File: rtl/dram_page_sequencer.sv
module dram_page_sequencer
  import dram_seq_pkg::*;
#(
  parameter int BANKS = 8,
  parameter int ROW_W = 14,
  parameter int COL_W = 10,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_rd,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [3:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  input  logic              force_en,
  input  logic [BANK_W-1:0] force_bank,
  input  logic [ROW_W-1:0]  force_row
);

  logic             lk_open;
  logic [ROW_W-1:0] lk_row;
  page_case_e       kind;
  seq_step_e        first_step;
  dram_cmd_e        access_cmd;
  dram_cmd_e        code_e;
  logic             busy;
  logic             take;
  logic             issued_open, issued_close;

  assign req_ready = !busy && !force_en;
  assign take      = req_valid && req_ready;

  pgseq_row_table #(.BANKS(BANKS), .ROW_W(ROW_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_bank    (req_bank),
    .lk_open    (lk_open),
    .lk_row     (lk_row),
    .open_en    (issued_open),
    .open_bank  (cmd_bank),
    .open_row   (cmd_row),
    .close_en   (issued_close),
    .close_bank (cmd_bank),
    .force_en   (force_en),
    .force_bank (force_bank),
    .force_row  (force_row)
  );

  pgseq_classifier #(.ROW_W(ROW_W)) u_class (
    .bank_open  (lk_open),
    .bank_row   (lk_row),
    .want_row   (req_row),
    .want_rd    (req_rd),
    .kind       (kind),
    .first_step (first_step),
    .access_cmd (access_cmd)
  );

  pgseq_issue #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_issue (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (take),
    .take_step    (first_step),
    .take_access  (access_cmd),
    .take_bank    (req_bank),
    .take_row     (req_row),
    .take_col     (req_col),
    .busy         (busy),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_code     (code_e),
    .cmd_bank     (cmd_bank),
    .cmd_row      (cmd_row),
    .cmd_col      (cmd_col),
    .issued_open  (issued_open),
    .issued_close (issued_close)
  );

  assign cmd_code = code_e;

endmodule

// File: rtl/dram_page_sequencer_chk.sv
module dram_page_sequencer_chk #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [3:0]        cmd_code,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [ROW_W-1:0]  cmd_row,
  input logic [COL_W-1:0]  cmd_col,
  input logic              force_en
);

  logic hs, hs_access;
  assign hs        = cmd_valid && cmd_ready;
  assign hs_access = hs && (cmd_code == 4'd3 || cmd_code == 4'd4);

  // R9: a stalled command holds still
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code) && $stable(cmd_bank)
                                   && $stable(cmd_row) && $stable(cmd_col)));

  // R3: close is always followed by open
  p_close_then_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && cmd_code == 4'd0) |=> (cmd_valid && cmd_code == 4'd2));

  // R2: open is always followed by the access
  p_open_then_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && cmd_code == 4'd2) |=> (cmd_valid && (cmd_code == 4'd3 || cmd_code == 4'd4)));

  // R5: only close, open, read and write appear
  p_legal_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_code == 4'd0 || cmd_code == 4'd2 || cmd_code == 4'd3 || cmd_code == 4'd4));

  // R8: no request taken while a sequence is in flight
  p_one_at_a_time_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);

  // R10: forced set-up blocks acceptance
  p_force_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    force_en |-> !req_ready);

  // R11: acceptance shows a command next cycle; access handover ends the sequence
  p_accept_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> cmd_valid);
  p_access_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hs_access |=> !cmd_valid);

endmodule

bind dram_page_sequencer dram_page_sequencer_chk #(
  .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_code  (cmd_code),
  .cmd_bank  (cmd_bank),
  .cmd_row   (cmd_row),
  .cmd_col   (cmd_col),
  .force_en  (force_en)
);

// File: tb/dram_page_sequencer_test.sv
`timescale 1ns/1ps
module dram_page_sequencer_test;

  localparam int BANKS  = 8;
  localparam int ROW_W  = 14;
  localparam int COL_W  = 10;
  localparam int BANK_W = 3;

  localparam logic [3:0] C_CLOSE = 4'd0;
  localparam logic [3:0] C_OPEN  = 4'd2;
  localparam logic [3:0] C_RD    = 4'd3;
  localparam logic [3:0] C_WR    = 4'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_rd = 1'b0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic cmd_valid, cmd_ready = 1'b1;
  logic [3:0] cmd_code;
  logic [BANK_W-1:0] cmd_bank;
  logic [ROW_W-1:0]  cmd_row;
  logic [COL_W-1:0]  cmd_col;
  logic force_en = 1'b0;
  logic [BANK_W-1:0] force_bank = '0;
  logic [ROW_W-1:0]  force_row = '0;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dram_page_sequencer #(.BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_rd(req_rd),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .force_en(force_en), .force_bank(force_bank), .force_row(force_row)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Send one request with cmd_ready high, compare the commands drawn.
  task automatic run_req(input int bank, input int row, input int col, input bit rd,
                         input int exp_n, input logic [11:0] exp_codes, input string tag);
    int got;
    @(negedge clk);
    check(req_ready == 1'b1, {tag, " R8 ready before request"}, int'(req_ready), 1);
    req_valid = 1'b1; req_bank = BANK_W'(bank); req_row = ROW_W'(row);
    req_col = COL_W'(col); req_rd = rd; cmd_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(cmd_valid == 1'b1, {tag, " R11 first command next cycle"}, int'(cmd_valid), 1);
    got = 0;
    for (int i = 0; i < 5; i++) begin
      if (!cmd_valid) break;
      if (got < 3) begin
        check(cmd_code == exp_codes[11-4*got -: 4], {tag, " command code"},
              int'(cmd_code), int'(exp_codes[11-4*got -: 4]));
        check(cmd_bank == BANK_W'(bank) && cmd_row == ROW_W'(row) && cmd_col == COL_W'(col),
              {tag, " R6 address carried"}, int'(cmd_row), row);
      end
      got++;
      @(negedge clk);
    end
    check(got == exp_n, {tag, " command count"}, got, exp_n);
    check(req_ready == 1'b1, {tag, " R11 ready after access"}, int'(req_ready), 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(req_ready == 1'b1, "R1 req_ready after reset", int'(req_ready), 1);
    check(cmd_valid == 1'b0, "R1 cmd_valid after reset", int'(cmd_valid), 0);
  endtask

  task automatic t_closed();
    run_req(0, 3, 1, 1'b1, 2, {C_OPEN, C_RD, 4'd0}, "R1 R2 closed bank read");
    run_req(7, 100, 2, 1'b0, 2, {C_OPEN, C_WR, 4'd0}, "R2 top bank write");
  endtask

  task automatic t_hit();
    run_req(0, 3, 1, 1'b1, 1, {C_RD, 8'd0}, "R4 R7 hit read");
    run_req(0, 3, 1, 1'b0, 1, {C_WR, 8'd0}, "R4 R5 hit write");
  endtask

  task automatic t_conflict();
    run_req(0, 4, 1, 1'b0, 3, {C_CLOSE, C_OPEN, C_WR}, "R3 conflict write");
    run_req(0, 3, 9, 1'b1, 3, {C_CLOSE, C_OPEN, C_RD}, "R3 R5 conflict read");
  endtask

  task automatic t_independent();
    run_req(1, 4, 1, 1'b1, 2, {C_OPEN, C_RD, 4'd0}, "R7 other bank closed");
    run_req(0, 3, 5, 1'b1, 1, {C_RD, 8'd0}, "R7 bank0 kept its row");
  endtask

  task automatic t_column();
    run_req(0, 3, 1023, 1'b0, 1, {C_WR, 8'd0}, "R6 column does not matter");
  endtask

  task automatic t_force();
    @(negedge clk);
    force_en = 1'b1; force_bank = 3'd2; force_row = 14'd9; req_valid = 1'b1;
    req_bank = 3'd5; req_row = 14'd1;
    #1;
    check(req_ready == 1'b0, "R10 ready low during force", int'(req_ready), 0);
    @(negedge clk);
    force_en = 1'b0; req_valid = 1'b0;
    check(cmd_valid == 1'b0, "R10 request not taken during force", int'(cmd_valid), 0);
    run_req(2, 9, 0, 1'b1, 1, {C_RD, 8'd0}, "R10 forced row hits");
    run_req(2, 1, 0, 1'b1, 3, {C_CLOSE, C_OPEN, C_RD}, "R10 forced row conflicts");
  endtask

  task automatic t_stall();
    @(negedge clk);
    cmd_ready = 1'b0; req_valid = 1'b1; req_bank = 3'd1; req_row = 14'd50;
    req_col = 10'd6; req_rd = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_bank = 3'd3; req_row = 14'd7;
    for (int i = 0; i < 3; i++) begin
      check(cmd_valid && cmd_code == C_CLOSE && cmd_row == 14'd50 && cmd_col == 10'd6,
            "R9 close held under stall", int'(cmd_code), int'(C_CLOSE));
      check(req_ready == 1'b0, "R8 ready low while busy", int'(req_ready), 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    cmd_ready = 1'b1;
    @(negedge clk);
    check(cmd_valid && cmd_code == C_OPEN && cmd_bank == 3'd1, "R11 open after close handover",
          int'(cmd_code), int'(C_OPEN));
    cmd_ready = 1'b0;
    @(negedge clk);
    check(cmd_valid && cmd_code == C_OPEN, "R9 open held under stall", int'(cmd_code), int'(C_OPEN));
    cmd_ready = 1'b1;
    @(negedge clk);
    check(cmd_valid && cmd_code == C_WR && cmd_row == 14'd50, "R5 write after stall",
          int'(cmd_code), int'(C_WR));
    @(negedge clk);
    check(!cmd_valid && req_ready, "R8 no second request entered", int'(cmd_valid), 0);
    run_req(3, 7, 0, 1'b1, 2, {C_OPEN, C_RD, 4'd0}, "R8 bank3 untouched by blocked request");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_closed();
    t_hit();
    t_conflict();
    t_independent();
    t_column();
    t_force();
    t_stall();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule